// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces a single programmed-I/O strobe cycle on a parallel disk channel. A request names the direction (read or write) and the port class (data port, or command/control port). The block picks the timing byte for that class, unpacks three phase lengths from it and steps through them. The phases are an address setup phase, an active phase with the strobe asserted and a hold phase with the address still driven. A one-clock done pulse follows the hold phase.

Each port class has its own timing byte, and both drives on the channel share it. The setup field is a plain count. The active and hold fields are indices into non-linear length tables, so one byte can cover both the slowest and the fastest transfer modes. When ready-wait is enabled, a device can stretch the active phase by holding its ready pin low.

Top module: `pio_cycle_gen`

## Requirements
- R1: While rst_ni is low and after it is released, addr_valid_o, rd_strobe_o, wr_strobe_o, data_latch_o, done_o and busy_o are all 0.
- R2: Timing byte bits [7:6] set the setup length. Codes 0,1,2,3 give 1,2,3,4 clocks of addr_valid_o high with no strobe, before the strobe rises.
- R3: Timing byte bits [2:0] set the active length. Codes 0..7 give 2,3,4,5,6,8,12,16 clocks of strobe high.
- R4: Timing byte bits [5:3] set the hold length. Codes 0..7 give 1,2,3,4,5,6,8,12 clocks of addr_valid_o high after the strobe falls.
- R5: With cmd_port_i=1 the cycle uses cmd_timing_i, and with cmd_port_i=0 it uses data_timing_i. The selection, the chosen byte and write_i are captured on the clock that accepts start_i. Later changes to them do not affect the running cycle.
- R6: When iordy_en_i=1 and iordy_i=0 during the last active clock, the active phase is extended one clock at a time until iordy_i is 1. When iordy_en_i=0, iordy_i has no effect.
- R7: The strobe is high only while addr_valid_o is high. addr_valid_o stays high without a break from the first setup clock to the last hold clock.
- R8: write_i=0 drives only rd_strobe_o and write_i=1 drives only wr_strobe_o. The two strobes are never high together.
- R9: For reads, data_latch_o is high for exactly one clock: the last active clock, at whose closing edge the read strobe falls. It never pulses for writes.
- R10: done_o is high for one clock right after the hold phase, with addr_valid_o low. busy_o is high from the clock after start_i is accepted through the done clock. Total busy time is setup+active+hold+1 clocks.
- R11: start_i is ignored while busy_o is high, including in the done clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one cycle (taken only when idle) |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_port_i | input | 1 | 1 = command/control port timing, 0 = data port timing |
| data_timing_i | input | 8 | Packed timing byte for data-port cycles |
| cmd_timing_i | input | 8 | Packed timing byte for command/control cycles |
| iordy_en_i | input | 1 | Enable stretching of the active phase by iordy_i |
| iordy_i | input | 1 | Device ready, synchronous to clk_i |
| addr_valid_o | output | 1 | Address/chip-select valid (setup, active, hold) |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| data_latch_o | output | 1 | One-clock pulse: capture read data at the next edge |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| busy_o | output | 1 | Cycle in progress |

## Verification
Two functions can fall on the same clock. The first pair is the read-data latch pulse and a ready stall: both are decided on the last active clock. The bench holds the ready pin low through that clock on stretched vectors. It then checks that the latch pulse appears only on the final, released clock and that the active count grows by the stall length. The second pair is the done pulse and a fresh start request. The bench raises start_i in the done clock and in the middle of a cycle, and changes the timing bytes and direction at the same time. It then checks that phase lengths and direction follow the captured values and that busy_o falls on the clock after done.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int TBYTE_W   = 8;
  localparam int CNT_W     = 5;   // holds up to 16 clocks
  localparam int NUM_CLASS = 2;   // 0 = data port, 1 = command/control port

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [TBYTE_W-1:0] tbyte_t;

  typedef struct packed {
    cnt_t setup;
    cnt_t active;
    cnt_t hold;
  } phase_len_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_DONE
  } pio_state_e;

  function automatic cnt_t setup_len(input logic [1:0] code);
    return cnt_t'(code) + cnt_t'(1);
  endfunction

  function automatic cnt_t active_len(input logic [2:0] code);
    case (code)
      3'd5:    return cnt_t'(8);
      3'd6:    return cnt_t'(12);
      3'd7:    return cnt_t'(16);
      default: return cnt_t'(code) + cnt_t'(2);
    endcase
  endfunction

  function automatic cnt_t hold_len(input logic [2:0] code);
    case (code)
      3'd6:    return cnt_t'(8);
      3'd7:    return cnt_t'(12);
      default: return cnt_t'(code) + cnt_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timing_pkg::*;
(
  input  tbyte_t     tbyte_i,
  output phase_len_t len_o
);

  // field positions: [7:6] setup, [5:3] hold, [2:0] active
  always_comb begin
    len_o.setup  = setup_len(tbyte_i[7:6]);
    len_o.hold   = hold_len(tbyte_i[5:3]);
    len_o.active = active_len(tbyte_i[2:0]);
  end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       write_i,
  input  phase_len_t len_i,
  input  logic       iordy_en_i,
  input  logic       iordy_i,
  output logic       addr_valid_o,
  output logic       rd_strobe_o,
  output logic       wr_strobe_o,
  output logic       data_latch_o,
  output logic       done_o,
  output logic       busy_o
);

  pio_state_e state_q;
  cnt_t       cnt_q;
  phase_len_t len_q;
  logic       wr_q;
  logic       last_q;
  logic       stall;

  assign last_q = (cnt_q == '0);
  assign stall  = iordy_en_i && !iordy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          len_q   <= len_i;
          wr_q    <= write_i;
          cnt_q   <= len_i.setup - cnt_t'(1);
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (last_q) begin
          cnt_q   <= len_q.active - cnt_t'(1);
          state_q <= ST_ACTIVE;
        end else begin
          cnt_q <= cnt_q - cnt_t'(1);
        end
        ST_ACTIVE: if (last_q) begin
          if (!stall) begin
            cnt_q   <= len_q.hold - cnt_t'(1);
            state_q <= ST_HOLD;
          end
        end else begin
          cnt_q <= cnt_q - cnt_t'(1);
        end
        ST_HOLD: if (last_q) begin
          state_q <= ST_DONE;
        end else begin
          cnt_q <= cnt_q - cnt_t'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_valid_o = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) || (state_q == ST_HOLD);
  assign rd_strobe_o  = (state_q == ST_ACTIVE) && !wr_q;
  assign wr_strobe_o  = (state_q == ST_ACTIVE) &&  wr_q;
  assign data_latch_o = rd_strobe_o && last_q && !stall;
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);

  a_r6_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && last_q && stall) |=> (rd_strobe_o || wr_strobe_o));
  a_r6_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && last_q && !iordy_en_i) |=> (state_q == ST_HOLD));
  a_r7_strobe_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_strobe_o || wr_strobe_o) |-> $past(addr_valid_o));
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_strobe_o, wr_strobe_o, done_o}));
  a_r9_latch_ends_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_latch_o |=> (!rd_strobe_o && addr_valid_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r10_done_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(addr_valid_o) && !addr_valid_o));
  a_r11_dir_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(wr_q));

endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
  import pio_timing_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       write_i,
  input  logic       cmd_port_i,
  input  logic [7:0] data_timing_i,
  input  logic [7:0] cmd_timing_i,
  input  logic       iordy_en_i,
  input  logic       iordy_i,
  output logic       addr_valid_o,
  output logic       rd_strobe_o,
  output logic       wr_strobe_o,
  output logic       data_latch_o,
  output logic       done_o,
  output logic       busy_o
);

  tbyte_t     tbytes [NUM_CLASS];
  phase_len_t lens   [NUM_CLASS];
  phase_len_t sel_len;

  assign tbytes[0] = data_timing_i;
  assign tbytes[1] = cmd_timing_i;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_dec
    pio_timing_decode u_dec (
      .tbyte_i (tbytes[g]),
      .len_o   (lens[g])
    );
  end

  assign sel_len = lens[cmd_port_i];

  pio_phase_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .write_i      (write_i),
    .len_i        (sel_len),
    .iordy_en_i   (iordy_en_i),
    .iordy_i      (iordy_i),
    .addr_valid_o (addr_valid_o),
    .rd_strobe_o  (rd_strobe_o),
    .wr_strobe_o  (wr_strobe_o),
    .data_latch_o (data_latch_o),
    .done_o       (done_o),
    .busy_o       (busy_o)
  );

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(addr_valid_o || rd_strobe_o || wr_strobe_o || data_latch_o || done_o));
  a_r10_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && addr_valid_o));

endmodule

// File: tb/pio_cycle_gen_tb.sv
module pio_cycle_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0, cmd_port_i = 1'b0;
  logic [7:0] data_timing_i = 8'hF5, cmd_timing_i = 8'hDE;
  logic iordy_en_i = 1'b0, iordy_i = 1'b1;
  logic addr_valid_o, rd_strobe_o, wr_strobe_o, data_latch_o, done_o, busy_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pio_cycle_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .write_i(write_i),
    .cmd_port_i(cmd_port_i), .data_timing_i(data_timing_i), .cmd_timing_i(cmd_timing_i),
    .iordy_en_i(iordy_en_i), .iordy_i(iordy_i),
    .addr_valid_o(addr_valid_o), .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o),
    .data_latch_o(data_latch_o), .done_o(done_o), .busy_o(busy_o)
  );

  typedef struct packed {
    logic       w;
    logic       c;
    logic [7:0] db;
    logic [7:0] cb;
    logic       en;
    logic [4:0] stall;
    logic [4:0] es;
    logic [4:0] ea;
    logic [4:0] eh;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'hF5, 8'hDE, 1'b0, 5'd0, 5'd4, 5'd8,  5'd8},
    '{1'b1, 1'b1, 8'hF5, 8'hDE, 1'b0, 5'd0, 5'd4, 5'd12, 5'd4},
    '{1'b0, 1'b0, 8'h09, 8'hDE, 1'b0, 5'd0, 5'd1, 5'd3,  5'd2},
    '{1'b1, 1'b0, 8'h00, 8'hDE, 1'b0, 5'd0, 5'd1, 5'd2,  5'd1},
    '{1'b0, 1'b1, 8'hF5, 8'hFF, 1'b0, 5'd0, 5'd4, 5'd16, 5'd12},
    '{1'b0, 1'b0, 8'h52, 8'hDE, 1'b1, 5'd3, 5'd2, 5'd7,  5'd3},
    '{1'b1, 1'b0, 8'h9B, 8'hDE, 1'b0, 5'd2, 5'd3, 5'd5,  5'd4},
    '{1'b0, 1'b1, 8'hF5, 8'h64, 1'b1, 5'd0, 5'd2, 5'd6,  5'd5},
    '{1'b0, 1'b0, 8'h2D, 8'hDE, 1'b1, 5'd1, 5'd1, 5'd9,  5'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge with the DUT idle
  task automatic run_vec(input vec_t v, input bit perturb);
    int s = 0, a = 0, h = 0, lat = 0, busyc = 0, badd = 0, n = 0;
    int anom = int'(v.ea) - (v.en ? int'(v.stall) : 0);
    bit done_seen = 1'b0;
    write_i = v.w; cmd_port_i = v.c; data_timing_i = v.db; cmd_timing_i = v.cb;
    iordy_en_i = v.en; iordy_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_seen && n < 200) begin
      begin
        bit stb = rd_strobe_o || wr_strobe_o;
        int ap = a + (stb ? 1 : 0);
        iordy_i = !(v.stall != 0 && stb && ap >= anom && ap < anom + int'(v.stall));
      end
      #1;
      if (busy_o) busyc++;
      if (rd_strobe_o || wr_strobe_o) begin
        a++;
        if (v.w ? rd_strobe_o : wr_strobe_o) badd++;
        if (data_latch_o) lat = a;
      end else if (addr_valid_o) begin
        if (a == 0) s++; else h++;
      end
      if (data_latch_o && v.w) badd++;
      if (done_o) begin
        done_seen = 1'b1;
        if (addr_valid_o) badd++;
      end
      if (perturb && n == 1) begin
        start_i = 1'b1; write_i = !v.w; cmd_port_i = !v.c;
        data_timing_i = 8'hFF; cmd_timing_i = 8'hFF;
      end
      if (perturb && n == 2) start_i = 1'b0;
      if (perturb && done_o) start_i = 1'b1;   // R11: start in the done clock
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    iordy_i = 1'b1;
    chk("R2 setup clocks", s, int'(v.es));
    chk("R3/R6 active clocks", a, int'(v.ea));
    chk("R4 hold clocks", h, int'(v.eh));
    chk("R9 latch position", lat, v.w ? 0 : int'(v.ea));
    chk("R8 direction/R7 ordering", badd, 0);
    chk("R10 busy length", busyc, int'(v.es) + int'(v.ea) + int'(v.eh) + 1);
    if (perturb) begin
      #1;
      chk("R11 start ignored in done clock", int'(busy_o), 0);
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    start_i = 1'b1;   // held during reset, must not start anything
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", int'({addr_valid_o, rd_strobe_o, wr_strobe_o, data_latch_o, done_o, busy_o}), 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 idle after reset", int'({addr_valid_o, rd_strobe_o, wr_strobe_o, data_latch_o, done_o, busy_o}), 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R5/R11: byte, class and direction changed mid-cycle with a second start
    run_vec('{1'b0, 1'b0, 8'h52, 8'hDE, 1'b0, 5'd0, 5'd2, 5'd4, 5'd3}, 1'b1);
    run_vec('{1'b1, 1'b1, 8'hF5, 8'h09, 1'b0, 5'd0, 5'd1, 5'd3, 5'd2}, 1'b1);

    // R6: enable set, ready held high, no stretch
    run_vec('{1'b1, 1'b0, 8'h00, 8'hDE, 1'b1, 5'd0, 5'd1, 5'd2, 5'd1}, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule